// File: doc/BRIEF.md
# Blink-Code Power Status LED Driver

This block drives one front-panel LED. A 2-bit mode input picks what the LED shows. The LED can be held dark, held lit, or made to follow a user LED input. The fourth choice is a power indicator. In that mode the LED reports the health of six supply rails.

In indicator mode the LED stays lit while every rail reports good. When a rail fails, the LED blinks a repeating burst of pulses, and the number of pulses names the rail. Rail input bit k is reported with k+1 pulses. If several rails are bad, the one with the fewest pulses wins. The burst length is captured when each burst begins, so a status change never cuts a burst short. A longer dark rest follows each burst before the next one starts.

All timing is counted in ticks of a clock-enable input. A parameter sets how many ticks make one time slot. Other parameters set how many slots the lit part of a pulse, the dark part of a pulse and the rest take. With a 1 kHz tick and the default values, a pulse is 200 ms lit and 200 ms dark, and the rest is 1 s.

Top module: `status_led_top`

## Requirements
- R1: With `mode_sel` = 2'b00 the LED is dark.
- R2: With `mode_sel` = 2'b11 the LED is lit.
- R3: With `mode_sel` = 2'b10 the LED follows `user_led` in the same cycle, with no register in between.
- R4: With `mode_sel` = 2'b01 and every `rail_ok` bit high, the LED is steadily lit.
- R5: With `mode_sel` = 2'b01 and only `rail_ok[k]` low, every burst holds exactly k+1 lit pulses.
- R6: When several `rail_ok` bits are low, the burst length is set by the lowest-numbered low bit.
- R7: The lit part of a pulse lasts MARK_SLOTS×TICKS_PER_SLOT ticks and the dark part lasts SPACE_SLOTS×TICKS_PER_SLOT ticks. After the dark part of the last pulse, the LED stays dark for a further REST_SLOTS×TICKS_PER_SLOT ticks. The LED changes on the clock edge at which the last tick of a phase is taken.
- R8: A change of `rail_ok` during a burst does not change the number of pulses in that burst.
- R9: Leaving indicator mode abandons the burst. When the mode returns to 2'b01, a complete new burst starts on the next clock edge.
- R10: Cycles without `tick` do not advance the pulse timing.
- R11: After a burst and its rest end, the rail status is evaluated again. If all rails are good, the LED is lit from that same edge.
- R12: While `rst_n` is low, the indicator sits at the burst start. With a rail failing in mode 2'b01, the LED is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable that paces all LED timing |
| mode_sel | input | 2 | 00 dark, 01 power indicator, 10 user input, 11 lit |
| rail_ok | input | RAILS | Power-good flags; bit k low gives k+1 pulses |
| user_led | input | 1 | LED level passed through in mode 10 |
| led | output | 1 | LED drive, high is lit |

## Verification
The bench builds the block with three ticks per slot, a one-slot pulse and a five-slot rest. With these values the longest burst, six pulses followed by its rest, fits in about fifty cycles. This lets every rail code, every multi-fault priority, a status change in mid-burst and a mode abort all be reached many times in a short run. The tick input is driven both steadily high and in irregular patterns. This exercises the edge at which each phase ends with and without stalls, and a stretch with no ticks shows that timing freezes.

// File: rtl/status_led_pkg.sv
package status_led_pkg;

  typedef enum logic [1:0] {
    LM_DARK  = 2'b00,
    LM_RAILS = 2'b01,
    LM_USER  = 2'b10,
    LM_LIT   = 2'b11
  } led_mode_e;

  typedef enum logic [1:0] {
    SQ_SCAN,
    SQ_MARK,
    SQ_SPACE,
    SQ_REST
  } seq_state_e;

  // Length of a sequencer phase in ticks.
  function automatic int unsigned phase_ticks(input seq_state_e s,
                                              input int unsigned tps,
                                              input int unsigned mark,
                                              input int unsigned space,
                                              input int unsigned rest);
    case (s)
      SQ_MARK:  return tps * mark;
      SQ_SPACE: return tps * space;
      SQ_REST:  return tps * rest;
      default:  return 1;
    endcase
  endfunction

  function automatic int unsigned longest3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/status_led_prio.sv
module status_led_prio #(
  parameter int RAILS = 6,
  parameter int CW    = $clog2(RAILS + 1)
) (
  input  logic [RAILS-1:0] rail_ok,
  output logic [CW-1:0]    code,
  output logic             any_bad
);

  logic [RAILS:0]   clean_below;
  logic [RAILS-1:0] first_bad;

  assign clean_below[0] = 1'b1;

  for (genvar k = 0; k < RAILS; k++) begin : g_chain
    assign first_bad[k]       = clean_below[k] & ~rail_ok[k];
    assign clean_below[k + 1] = clean_below[k] & rail_ok[k];
  end

  always_comb begin
    code = '0;
    for (int k = 0; k < RAILS; k++) begin
      if (first_bad[k]) code = code | CW'(k + 1);
    end
  end

  assign any_bad = ~clean_below[RAILS];

endmodule

// File: rtl/status_led_timer.sv
module status_led_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] count;

  assign expired = tick && (count == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) count <= '0;
    else if (tick)         count <= count + 1'b1;
  end

  assert_count_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count < limit)
    else $error("timer count passed its phase length");

endmodule

// File: rtl/status_led_seq.sv
module status_led_seq
  import status_led_pkg::*;
#(
  parameter int TICKS_PER_SLOT = 200,
  parameter int MARK_SLOTS     = 1,
  parameter int SPACE_SLOTS    = 1,
  parameter int REST_SLOTS     = 5,
  parameter int CW             = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] fault_code,
  input  logic          any_bad,
  output logic          lit,
  output logic          burst_start,
  output logic          phase_end
);

  localparam int unsigned MAXT = longest3(TICKS_PER_SLOT * MARK_SLOTS,
                                          TICKS_PER_SLOT * SPACE_SLOTS,
                                          TICKS_PER_SLOT * REST_SLOTS);
  localparam int TW = $clog2(MAXT + 1);

  seq_state_e    state;
  logic [CW-1:0] burst_len;
  logic [CW-1:0] pulse_no;
  logic [TW-1:0] limit;
  logic          restart;
  logic          last_pulse;

  assign limit       = TW'(phase_ticks(state, TICKS_PER_SLOT, MARK_SLOTS,
                                       SPACE_SLOTS, REST_SLOTS));
  assign burst_start = run && (state == SQ_SCAN) && any_bad;
  assign restart     = !run || (state == SQ_SCAN) || phase_end;
  assign last_pulse  = (pulse_no == burst_len);

  status_led_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .limit   (limit),
    .expired (phase_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_SCAN;
      burst_len <= '0;
      pulse_no  <= '0;
    end else if (!run) begin
      state <= SQ_SCAN;
    end else begin
      case (state)
        SQ_SCAN: if (burst_start) begin
          burst_len <= fault_code;
          pulse_no  <= CW'(1);
          state     <= SQ_MARK;
        end
        SQ_MARK: if (phase_end) state <= SQ_SPACE;
        SQ_SPACE: if (phase_end) begin
          if (last_pulse) state <= SQ_REST;
          else begin
            pulse_no <= pulse_no + 1'b1;
            state    <= SQ_MARK;
          end
        end
        SQ_REST: if (phase_end) state <= SQ_SCAN;
        default: state <= SQ_SCAN;
      endcase
    end
  end

  assign lit = (state == SQ_MARK) || ((state == SQ_SCAN) && !any_bad);

  assert_pulse_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SQ_SCAN) |-> (pulse_no >= CW'(1) && pulse_no <= burst_len))
    else $error("pulse index outside its burst");

  assert_burst_len_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SQ_SCAN && $past(state) != SQ_SCAN) |-> $stable(burst_len))
    else $error("burst length changed inside a burst");

  assert_stall_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && state != SQ_SCAN) |=> (state == $past(state)))
    else $error("phase advanced without a tick");

  assert_rest_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_REST && $past(state) != SQ_REST) |->
      ($past(state) == SQ_SPACE && $past(pulse_no) == $past(burst_len)))
    else $error("rest entered before the last pulse");

endmodule

// File: rtl/status_led_top.sv
module status_led_top
  import status_led_pkg::*;
#(
  parameter int RAILS          = 6,
  parameter int TICKS_PER_SLOT = 200,
  parameter int MARK_SLOTS     = 1,
  parameter int SPACE_SLOTS    = 1,
  parameter int REST_SLOTS     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       mode_sel,
  input  logic [RAILS-1:0] rail_ok,
  input  logic             user_led,
  output logic             led
);

  localparam int CW = $clog2(RAILS + 1);

  led_mode_e     mode;
  logic [CW-1:0] fault_code;
  logic          any_bad;
  logic          ind_lit;
  logic          burst_start;
  logic          phase_end;

  assign mode = led_mode_e'(mode_sel);

  status_led_prio #(.RAILS(RAILS), .CW(CW)) u_prio (
    .rail_ok (rail_ok),
    .code    (fault_code),
    .any_bad (any_bad)
  );

  status_led_seq #(
    .TICKS_PER_SLOT (TICKS_PER_SLOT),
    .MARK_SLOTS     (MARK_SLOTS),
    .SPACE_SLOTS    (SPACE_SLOTS),
    .REST_SLOTS     (REST_SLOTS),
    .CW             (CW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (mode == LM_RAILS),
    .tick        (tick),
    .fault_code  (fault_code),
    .any_bad     (any_bad),
    .lit         (ind_lit),
    .burst_start (burst_start),
    .phase_end   (phase_end)
  );

  always_comb begin
    unique case (mode)
      LM_DARK:  led = 1'b0;
      LM_RAILS: led = ind_lit;
      LM_USER:  led = user_led;
      LM_LIT:   led = 1'b1;
      default:  led = 1'b0;
    endcase
  end

  assert_prio_picks_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_bad |-> (fault_code != '0 && !rail_ok[fault_code - 1'b1]
                 && (&(rail_ok | ~((RAILS'(1) << (fault_code - 1'b1)) - 1'b1)))))
    else $error("fault code does not name the lowest failing rail");

  assert_dark_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> !led)
    else $error("LED lit in dark mode");

  assert_lit_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> led)
    else $error("LED dark in lit mode");

  assert_start_is_dark_R12: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> !led)
    else $error("LED lit on a burst start cycle");

  assert_phase_only_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |-> tick)
    else $error("phase ended without a tick");

endmodule

// File: tb/status_led_top_test.sv
module status_led_top_test;

  localparam int T = 3, MS = 1, SS = 1, RS = 5, NR = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic [1:0]    mode_sel = 2'b01;
  logic [NR-1:0] rail_ok = 6'b111110;
  logic          user_led = 1'b0;
  logic          led;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  status_led_top #(
    .RAILS(NR), .TICKS_PER_SLOT(T), .MARK_SLOTS(MS),
    .SPACE_SLOTS(SS), .REST_SLOTS(RS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
    .rail_ok(rail_ok), .user_led(user_led), .led(led)
  );

  function automatic int worst_rail(input logic [NR-1:0] ok);
    for (int k = 0; k < NR; k++) if (!ok[k]) return k + 1;
    return 0;
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 start, 1 lit pulse, 2 dark pulse, 3 rest.
  int phase = 0, left = 0, to_go = 0;

  function automatic bit model_led();
    case (mode_sel)
      2'b00: return 1'b0;
      2'b11: return 1'b1;
      2'b10: return user_led;
      default: return (phase == 1) || (phase == 0 && worst_rail(rail_ok) == 0);
    endcase
  endfunction

  always @(posedge clk) begin
    int c;
    string tag;
    if (!rst_n || mode_sel != 2'b01) phase = 0;
    else begin
      case (phase)
        0: begin
          c = worst_rail(rail_ok);
          if (c != 0) begin phase = 1; left = MS * T; to_go = c; end
        end
        1: if (tick) begin
          left--;
          if (left == 0) begin phase = 2; left = SS * T; end
        end
        2: if (tick) begin
          left--;
          if (left == 0) begin
            to_go--;
            if (to_go == 0) begin phase = 3; left = RS * T; end
            else begin phase = 1; left = MS * T; end
          end
        end
        default: if (tick) begin
          left--;
          if (left == 0) phase = 0;
        end
      endcase
    end
    #2;
    if (rst_n) begin
      case (mode_sel)
        2'b00: tag = "R1";
        2'b11: tag = "R2";
        2'b10: tag = "R3";
        default: tag = (worst_rail(rail_ok) == 0 && phase == 0) ? "R4" : "R7";
      endcase
      check(led == model_led(), tag, led, model_led());
    end
  end

  // Restart the indicator with the given rail flags.
  task automatic restart_with(input logic [NR-1:0] ok);
    @(negedge clk);
    mode_sel = 2'b00;
    @(negedge clk);
    rail_ok  = ok;
    mode_sel = 2'b01;
  endtask

  // Count lit pulses across one burst; optionally change rails after n cycles.
  task automatic count_burst(input int c_exp, input string req,
                             input int change_at, input logic [NR-1:0] new_ok);
    int n = 0;
    logic prev = 1'b0;
    int win = 1 + c_exp * (MS + SS) * T + RS * T;
    for (int i = 0; i < win - 1; i++) begin
      @(posedge clk); #2;
      if (led && !prev) n++;
      prev = led;
      if (i == change_at) rail_ok = new_ok;
    end
    check(n == c_exp, req, n, c_exp);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lit_cnt;
    repeat (3) @(negedge clk);
    check(led == 1'b0, "R12", led, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1, R2, R3
    mode_sel = 2'b00; #1 check(led == 1'b0, "R1", led, 0);
    @(negedge clk); mode_sel = 2'b11; #1 check(led == 1'b1, "R2", led, 1);
    @(negedge clk); mode_sel = 2'b10; user_led = 1'b1; #1 check(led == 1'b1, "R3", led, 1);
    @(negedge clk); user_led = 1'b0; #1 check(led == 1'b0, "R3", led, 0);

    // R4
    @(negedge clk); rail_ok = '1; mode_sel = 2'b01;
    lit_cnt = 0;
    for (int i = 0; i < 40; i++) begin @(posedge clk); #2; if (led) lit_cnt++; end
    check(lit_cnt == 40, "R4", lit_cnt, 40);

    // R5: each rail alone
    for (int k = 0; k < NR; k++) begin
      restart_with(~(NR'(1) << k));
      count_burst(k + 1, "R5", -1, '0);
    end

    // R6: several rails bad
    restart_with(6'b101011 & ~6'b010100);
    count_burst(3, "R6", -1, '0);
    restart_with(6'b011110);
    count_burst(1, "R6", -1, '0);

    // R8 then R11: rails recover mid-burst
    restart_with(6'b111011);
    count_burst(3, "R8", 4, '1);
    @(posedge clk); #2;
    check(led == 1'b1, "R11", led, 1);

    // R9: abort and restart a burst
    restart_with(6'b101111);
    repeat (10) @(negedge clk);
    mode_sel = 2'b00;
    @(negedge clk); mode_sel = 2'b01;
    @(posedge clk); #2 check(led == 1'b1, "R9", led, 1);
    @(negedge clk); mode_sel = 2'b00;
    @(negedge clk); mode_sel = 2'b01;
    count_burst(5, "R9", -1, '0);

    // R10: no ticks freezes the lit phase
    @(negedge clk); mode_sel = 2'b00;
    @(negedge clk); tick = 1'b0; rail_ok = 6'b111101; mode_sel = 2'b01;
    lit_cnt = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk); #2; if (led) lit_cnt++; end
    check(lit_cnt == 30, "R10", lit_cnt, 30);
    @(negedge clk); tick = 1'b1;
    repeat (60) @(negedge clk);

    // Irregular stimulus, compared each cycle by the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick = (($urandom % 3) == 0);
      user_led = $urandom % 2;
      if (($urandom % 250) == 0) mode_sel = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
      if (($urandom % 120) == 0) begin
        rail_ok = '1;
        if ($urandom % 4 != 0) rail_ok[$urandom % NR] = 1'b0;
        if ($urandom % 3 == 0) rail_ok[$urandom % NR] = 1'b0;
      end
    end

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule